// File: doc/BRIEF.md
# Time-Sliced Shared Memory Arbiter with Derived Host Clock

This block lets a fast accelerator and a slow 8-bit host processor use one single-cycle SRAM without ever contending for it. A free-running phase counter splits the fast clock into frames of eight cycles and produces the host's clock from them: high for the first four phases, low for the last four. One phase in each frame belongs to the host. The host request is captured at the start of the frame, served in the host phase, and its read data is then held steady. From the host's side the memory behaves like a private, zero-wait-state device.

The remaining phases serve the accelerator through a level request and a one-cycle grant pulse. A four-entry address window at the top of the host map is not sent to RAM. It maps onto four accelerator-owned registers: board state, evaluation score, check map and next move. The host can read and write them like memory. The accelerator loads them through its own update port.

Top module: `slot_mem_arbiter`

## Requirements
- R1: The host clock `hostClk` repeats every 8 fast cycles. It is high in phases 0–3 and low in phases 4–7. After reset ends, the first cycle is phase 0.
- R2: The host bus (`hostEn`, `hostWe`, `hostAddr`, `hostWdata`) is sampled at the end of phase 0. The access is performed in phase 3 of the same frame, so every frame serves one host access with no wait state.
- R3: Host read data appears on `hostRdata` at the end of phase 3. It stays unchanged through all other phases. A frame with `hostEn` low leaves it unchanged.
- R4: An accelerator request seen in a phase other than 3 is served in that cycle. `accGnt` goes high for exactly one cycle on the next cycle, and `accRdata` carries the read data during that grant cycle.
- R5: An accelerator request first raised in phase 3 is deferred. It is served in phase 4, and the grant is seen two edges after the request.
- R6: Host addresses `PROXY_BASE`..`PROXY_BASE+3` form the register window. The register index is the address's low two bits: 0 board, 1 score, 2 check map, 3 next move. A host write into the window updates that register, and RAM is neither strobed nor changed.
- R7: A host read inside the window returns the register value, not RAM contents.
- R8: When `accRegWe` is high, `accRegData` is loaded into register `accRegIdx`. If the host writes the same register in the same cycle, the host value wins. All four registers are visible on `proxyRegs`, with index i at bits [8i+7:8i].
- R9: While `rst` is high, the phase counter is held at 0 and `hostClk` is high. `sramCe`, `sramWe` and `accGnt` are low, even with a pending accelerator request. `hostRdata` and the window registers are cleared.
- R10: In phase 3 the SRAM pins carry only the host access. A simultaneous accelerator request neither corrupts the host data nor is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| hostClk | output | 1 | Derived host clock (fast clock / 8) |
| hostEn | input | 1 | Host access request for this frame |
| hostWe | input | 1 | Host access is a write (1) or read (0) |
| hostAddr | input | ADDR_W | Host address |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data, held between host slots |
| accReq | input | 1 | Accelerator request, held until grant |
| accWe | input | 1 | Accelerator access is a write |
| accAddr | input | ADDR_W | Accelerator RAM address |
| accWdata | input | DATA_W | Accelerator write data |
| accGnt | output | 1 | One-cycle completion pulse |
| accRdata | output | DATA_W | Accelerator read data, valid with grant |
| accRegWe | input | 1 | Accelerator update of a window register |
| accRegIdx | input | 2 | Window register index to update |
| accRegData | input | DATA_W | Window register update value |
| proxyRegs | output | 4*DATA_W | All window registers, flattened |
| sramCe | output | 1 | SRAM chip enable |
| sramWe | output | 1 | SRAM write enable |
| sramAddr | output | ADDR_W | SRAM address |
| sramWdata | output | DATA_W | SRAM write data |
| sramRdata | input | DATA_W | SRAM read data, same cycle |

## Verification
The bench aims at the places where slot timing goes wrong.

- **Request landing on the host phase.** A request raised exactly in phase 3 must wait one cycle. A design that served it there would corrupt the host read, or drop one of the two accesses.
- **Grant length.** The grant must last one cycle while the requester still holds its request. A design that re-armed immediately would produce a double grant and a second write.
- **Register window.** Window writes must not strobe RAM. A design that passed them through would overwrite a preloaded RAM word. Window reads must return the register value, not the preloaded RAM word.
- **Same-cycle register writes.** When the host and the accelerator hit the same register in one cycle, the host value must win.
- **Idle frames and reset.** An idle frame must not disturb held read data. Reset asserted with a request pending must restart the frame at phase 0 without issuing a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Per-cycle slot decision handed from control to datapath
  typedef struct packed {
    logic latchHost;  // end of phase 0: capture host bus
    logic hostSlot;   // host access phase
    logic accSlot;    // accelerator served this cycle
  } slotStrobe_t;
endpackage

// File: rtl/arb_ctl.sv
module arb_ctl
  import arb_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 8,
  parameter int unsigned HOST_PHASE = 3,
  localparam int unsigned PHASE_W = $clog2(NUM_PHASES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accReq,
  output logic [PHASE_W-1:0] phase,
  output logic               hostClk,
  output logic               accGnt,
  output slotStrobe_t        strobe
);
  localparam logic [PHASE_W-1:0] LAST_P = PHASE_W'(NUM_PHASES - 1);
  localparam logic [PHASE_W-1:0] HOST_P = PHASE_W'(HOST_PHASE);
  localparam logic [PHASE_W-1:0] HALF_P = PHASE_W'(NUM_PHASES / 2);

  logic [PHASE_W-1:0] phaseQ;
  logic               gntQ;

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= '0;
    else if (phaseQ == LAST_P) phaseQ <= '0;
    else phaseQ <= phaseQ + 1'b1;
  end

  always_comb begin
    strobe.latchHost = !rst && (phaseQ == '0);
    strobe.hostSlot  = !rst && (phaseQ == HOST_P);
    strobe.accSlot   = !rst && (phaseQ != HOST_P) && accReq && !gntQ;
  end

  always_ff @(posedge clk) begin
    if (rst) gntQ <= 1'b0;
    else gntQ <= strobe.accSlot;
  end

  assign phase   = phaseQ;
  assign hostClk = (phaseQ < HALF_P);
  assign accGnt  = gntQ;
endmodule

// File: rtl/arb_dp.sv
module arb_dp
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_PROXY  = 4,
  parameter int unsigned PROXY_BASE = 'h3FC,
  localparam int unsigned IDX_W = $clog2(NUM_PROXY)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  slotStrobe_t                 strobe,
  input  logic                        hostEn,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [DATA_W-1:0]           hostRdata,
  input  logic                        accWe,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic [DATA_W-1:0]           accWdata,
  output logic [DATA_W-1:0]           accRdata,
  input  logic                        accRegWe,
  input  logic [IDX_W-1:0]            accRegIdx,
  input  logic [DATA_W-1:0]           accRegData,
  output logic [NUM_PROXY*DATA_W-1:0] proxyRegs,
  output logic                        sramCe,
  output logic                        sramWe,
  output logic [ADDR_W-1:0]           sramAddr,
  output logic [DATA_W-1:0]           sramWdata,
  input  logic [DATA_W-1:0]           sramRdata
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(PROXY_BASE);

  logic              hostEnQ, hostWeQ;
  logic [ADDR_W-1:0] hostAddrQ;
  logic [DATA_W-1:0] hostWdataQ, hostRdataQ, accRdataQ;
  logic [DATA_W-1:0] regQ [NUM_PROXY];
  logic              inWin, hostHit;
  logic [IDX_W-1:0]  hostIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hostEnQ    <= 1'b0;
      hostWeQ    <= 1'b0;
      hostAddrQ  <= '0;
      hostWdataQ <= '0;
    end else if (strobe.latchHost) begin
      hostEnQ    <= hostEn;
      hostWeQ    <= hostWe;
      hostAddrQ  <= hostAddr;
      hostWdataQ <= hostWdata;
    end
  end

  assign inWin   = (hostAddrQ[ADDR_W-1:IDX_W] == BASE_V[ADDR_W-1:IDX_W]);
  assign hostIdx = hostAddrQ[IDX_W-1:0];
  assign hostHit = strobe.hostSlot && hostEnQ;

  always_comb begin
    sramCe    = (hostHit && !inWin) || strobe.accSlot;
    sramWe    = hostHit ? (hostWeQ && !inWin) : (strobe.accSlot && accWe);
    sramAddr  = hostHit ? hostAddrQ : accAddr;
    sramWdata = hostHit ? hostWdataQ : accWdata;
  end

  for (genvar i = 0; i < NUM_PROXY; i++) begin : g_proxy
    always_ff @(posedge clk) begin
      if (rst) regQ[i] <= '0;
      else if (hostHit && hostWeQ && inWin && hostIdx == IDX_W'(i)) regQ[i] <= hostWdataQ;
      else if (accRegWe && accRegIdx == IDX_W'(i)) regQ[i] <= accRegData;
    end
    assign proxyRegs[i*DATA_W +: DATA_W] = regQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) hostRdataQ <= '0;
    else if (hostHit && !hostWeQ) hostRdataQ <= inWin ? regQ[hostIdx] : sramRdata;
  end

  always_ff @(posedge clk) begin
    if (rst) accRdataQ <= '0;
    else if (strobe.accSlot && !accWe) accRdataQ <= sramRdata;
  end

  assign hostRdata = hostRdataQ;
  assign accRdata  = accRdataQ;
endmodule

// File: rtl/slot_mem_arbiter.sv
module slot_mem_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_PROXY  = 4,
  parameter int unsigned PROXY_BASE = 'h3FC,
  parameter int unsigned NUM_PHASES = 8,
  parameter int unsigned HOST_PHASE = 3,
  localparam int unsigned IDX_W   = $clog2(NUM_PROXY),
  localparam int unsigned PHASE_W = $clog2(NUM_PHASES)
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic                        hostClk,
  input  logic                        hostEn,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [DATA_W-1:0]           hostRdata,
  input  logic                        accReq,
  input  logic                        accWe,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic [DATA_W-1:0]           accWdata,
  output logic                        accGnt,
  output logic [DATA_W-1:0]           accRdata,
  input  logic                        accRegWe,
  input  logic [IDX_W-1:0]            accRegIdx,
  input  logic [DATA_W-1:0]           accRegData,
  output logic [NUM_PROXY*DATA_W-1:0] proxyRegs,
  output logic                        sramCe,
  output logic                        sramWe,
  output logic [ADDR_W-1:0]           sramAddr,
  output logic [DATA_W-1:0]           sramWdata,
  input  logic [DATA_W-1:0]           sramRdata
);
  slotStrobe_t        strobe;
  logic [PHASE_W-1:0] phase;

  arb_ctl #(.NUM_PHASES(NUM_PHASES), .HOST_PHASE(HOST_PHASE)) u_ctl (
    .clk(clk), .rst(rst), .accReq(accReq), .phase(phase),
    .hostClk(hostClk), .accGnt(accGnt), .strobe(strobe)
  );

  arb_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROXY(NUM_PROXY),
           .PROXY_BASE(PROXY_BASE)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .accRdata(accRdata), .accRegWe(accRegWe), .accRegIdx(accRegIdx),
    .accRegData(accRegData), .proxyRegs(proxyRegs), .sramCe(sramCe),
    .sramWe(sramWe), .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata)
  );
endmodule

// File: rtl/slot_mem_arbiter_chk.sv
module slot_mem_arbiter_chk #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROXY_BASE = 'h3FC,
  parameter int unsigned HOST_PHASE = 3,
  parameter int unsigned PHASE_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] phase,
  input logic               hostClk,
  input logic               accGnt,
  input logic [DATA_W-1:0]  hostRdata,
  input logic               sramCe,
  input logic [ADDR_W-1:0]  sramAddr
);
  localparam logic [PHASE_W-1:0] HP = PHASE_W'(HOST_PHASE);
  localparam logic [ADDR_W-1:0]  BASE_V = ADDR_W'(PROXY_BASE);

  // R1
  clk_high_four_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hostClk) |=> hostClk ##1 hostClk ##1 hostClk ##1 !hostClk);

  // R4
  gnt_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    accGnt |=> !accGnt);

  // R10
  no_acc_in_host_slot_chk: assert property (@(posedge clk) disable iff (rst)
    accGnt |-> ($past(phase) != HP));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != HP) |=> $stable(hostRdata));

  // R6
  window_not_in_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == HP && sramCe) |-> (sramAddr[ADDR_W-1:2] != BASE_V[ADDR_W-1:2]));

  // R9
  no_gnt_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    accGnt |-> !$past(rst));
endmodule

bind slot_mem_arbiter slot_mem_arbiter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROXY_BASE(PROXY_BASE),
  .HOST_PHASE(HOST_PHASE), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .hostClk(hostClk), .accGnt(accGnt),
  .hostRdata(hostRdata), .sramCe(sramCe), .sramAddr(sramAddr)
);

// File: tb/slot_mem_arbiter_bench.sv
module slot_mem_arbiter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic hostClk, hostEn, hostWe, accReq, accWe, accGnt, accRegWe, sramCe, sramWe;
  logic [9:0] hostAddr, accAddr, sramAddr;
  logic [7:0] hostWdata, hostRdata, accWdata, accRdata, accRegData, sramWdata, sramRdata;
  logic [1:0] accRegIdx;
  logic [31:0] proxyRegs;
  logic [7:0] mem [1024];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  slot_mem_arbiter u_slot_mem_arbiter (
    .clk(clk), .rst(rst), .hostClk(hostClk), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .accReq(accReq), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .accGnt(accGnt), .accRdata(accRdata), .accRegWe(accRegWe), .accRegIdx(accRegIdx),
    .accRegData(accRegData), .proxyRegs(proxyRegs), .sramCe(sramCe), .sramWe(sramWe),
    .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata)
  );

  assign sramRdata = mem[sramAddr];
  always @(posedge clk) if (sramCe && sramWe) mem[sramAddr] <= sramWdata;

  typedef struct packed {
    logic       we;
    logic [9:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 10'h010, 8'hA5, 8'h00},
    '{1'b1, 10'h3FD, 8'h3C, 8'h00},
    '{1'b0, 10'h010, 8'h00, 8'hA5},
    '{1'b0, 10'h3FD, 8'h00, 8'h3C},
    '{1'b1, 10'h020, 8'h11, 8'h00},
    '{1'b1, 10'h021, 8'h22, 8'h00},
    '{1'b0, 10'h021, 8'h00, 8'h22},
    '{1'b0, 10'h020, 8'h00, 8'h11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostFrame(input logic en, input logic we, input logic [9:0] a,
                           input logic [7:0] d);
    @(negedge hostClk); #1;
    hostEn = en; hostWe = we; hostAddr = a; hostWdata = d;
    @(negedge hostClk); #1;
    hostEn = 1'b0;
  endtask

  task automatic accAccess(input logic we, input logic [9:0] a, input logic [7:0] d,
                           output int edges, output logic [7:0] rd);
    accReq = 1'b1; accWe = we; accAddr = a; accWdata = d;
    edges = 0; rd = '0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      edges++;
      if (accGnt) begin
        rd = accRdata;
        break;
      end
    end
    accReq = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int edges;
    logic [7:0] rd;
    int bad;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[10'h3FD] = 8'h77;
    mem[10'h3FE] = 8'h66;
    hostEn = 0; hostWe = 0; hostAddr = '0; hostWdata = '0;
    accReq = 1; accWe = 1; accAddr = 10'h005; accWdata = 8'hEE;
    accRegWe = 0; accRegIdx = '0; accRegData = '0;

    // R9: reset state with a pending accelerator request
    repeat (3) @(negedge clk);
    chk("R9 sramCe in reset", sramCe, 0);
    chk("R9 accGnt in reset", accGnt, 0);
    chk("R9 hostClk in reset", hostClk, 1);
    chk("R9 hostRdata in reset", hostRdata, 0);
    chk("R9 proxyRegs in reset", proxyRegs, 0);
    chk("R9 RAM untouched in reset", mem[10'h005], 8'h00);
    accReq = 0;
    rst = 0;

    // R1: phase n after n edges; hostClk high for n%8 < 4
    bad = 0;
    for (int n = 1; n <= 16; n++) begin
      @(posedge clk); #1;
      if (hostClk !== ((n % 8) < 4)) bad++;
    end
    chk("R1 hostClk pattern mismatches", bad, 0);

    // R2 R3 R6 R7: vector table of host frames
    for (int v = 0; v < 8; v++) begin
      hostFrame(1'b1, VECS[v].we, VECS[v].addr, VECS[v].wdata);
      if (!VECS[v].we) chk("R2 host vector read", hostRdata, VECS[v].exp);
    end
    chk("R6 window write skips RAM", mem[10'h3FD], 8'h77);
    chk("R6 window write reaches reg1", proxyRegs[15:8], 8'h3C);

    // R3: idle frame keeps last read value
    hostFrame(1'b0, 1'b0, 10'h010, 8'h00);
    chk("R3 idle frame holds rdata", hostRdata, 8'h11);

    // R8 R7: accelerator loads reg2, host reads it
    @(negedge clk); accRegWe = 1; accRegIdx = 2'd2; accRegData = 8'h5E;
    @(negedge clk); accRegWe = 0;
    chk("R8 acc update reg2", proxyRegs[23:16], 8'h5E);
    hostFrame(1'b1, 1'b0, 10'h3FE, 8'h00);
    chk("R7 window read returns reg not RAM", hostRdata, 8'h5E);

    // R4: request in a free phase (phase 4), one edge to grant
    @(negedge hostClk); #1;
    accAccess(1'b1, 10'h040, 8'hC3, edges, rd);
    chk("R4 free-phase grant latency", edges, 1);
    @(posedge clk); #1;
    chk("R4 grant lasts one cycle", accGnt, 0);
    chk("R4 acc write stored", mem[10'h040], 8'hC3);
    hostFrame(1'b1, 1'b0, 10'h040, 8'h00);
    chk("R4 host sees acc write", hostRdata, 8'hC3);

    // R4: accelerator read of host-written data
    hostFrame(1'b1, 1'b1, 10'h050, 8'h99);
    @(negedge clk);
    accAccess(1'b0, 10'h050, 8'h00, edges, rd);
    chk("R4 acc read data with grant", rd, 8'h99);

    // R5 R10: request raised in phase 3 while host reads 0x010
    @(negedge hostClk); #1;
    hostEn = 1; hostWe = 0; hostAddr = 10'h010;
    @(posedge hostClk); #1;
    repeat (3) @(posedge clk);
    #1;
    accAccess(1'b1, 10'h060, 8'h4D, edges, rd);
    hostEn = 0;
    chk("R5 deferred grant latency", edges, 2);
    @(negedge hostClk); #1;
    chk("R10 host read intact in shared frame", hostRdata, 8'hA5);
    chk("R10 acc write not lost", mem[10'h060], 8'h4D);

    // R8: host and accelerator write reg3 in the same cycle; host wins
    @(negedge hostClk); #1;
    hostEn = 1; hostWe = 1; hostAddr = 10'h3FF; hostWdata = 8'hE7;
    @(posedge hostClk); #1;
    repeat (3) @(posedge clk);
    #1;
    accRegWe = 1; accRegIdx = 2'd3; accRegData = 8'h11;
    @(posedge clk); #1;
    accRegWe = 0; hostEn = 0;
    chk("R8 host wins same-cycle reg write", proxyRegs[31:24], 8'hE7);

    // R9 R1: reset mid-run with request pending, frame restarts at phase 0
    @(negedge clk); rst = 1; accReq = 1; accWe = 1; accAddr = 10'h070; accWdata = 8'h3A;
    @(negedge clk); @(negedge clk);
    chk("R9 no strobe in mid-run reset", sramCe, 0);
    chk("R9 no grant in mid-run reset", accGnt, 0);
    chk("R9 regs cleared", proxyRegs, 0);
    accReq = 0; rst = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 hostClk high in phase 3 after reset", hostClk, 1);
    @(posedge clk); #1;
    chk("R1 hostClk low in phase 4 after reset", hostClk, 0);
    chk("R9 pending request dropped", mem[10'h070], 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule